// File: doc/BRIEF.md
# Wormhole Header-Deletion Router

This block steers packets arriving on three serial link channels toward one of four sinks: the transmit side of the other two links, or a local receive FIFO. Each link and the local node holds a programmable 8-bit address. With routing switched on, the leading character of every packet is read as the destination, compared against the addresses and then discarded. The rest of the packet, through its end marker, goes to the chosen sink. A sink stays reserved for one source from the grant until that packet's end marker has been passed on, so packets never interleave. A source that targets a reserved sink is stalled through its ready signal. When two sources reach a free sink in the same cycle, they are taken in round-robin order.

A destination that matches no eligible address is not dropped. It is delivered to the local FIFO, and a sticky error bit is set. That bit is cleared by a one-cycle clear pulse, and a mask bit gates it onto an interrupt line. With routing switched off, the block is a plain transparent path: every packet reaches the local FIFO untouched and nothing is decoded.

Characters are 9 bits wide. Bit 8 set marks a control character. A control character ends a packet, and its bit 0 tells a normal end (0) from an error end (1). The handshake is valid/ready. A character moves in a cycle where valid and ready are both high at the rising clock edge.

Top module: `wh_router`

## Requirements
- R1: After reset no output is valid, the error bit and the interrupt are low, and with routing enabled every input shows ready.
- R2: With routing enabled, the first data character of a packet on input i is consumed and never appears at any output. The following characters, up to and including the end marker, appear in order on the selected output.
- R3: Outputs 0 to 2 are the transmit sides of links 0 to 2, and output 3 is the local FIFO. The destination is the lowest-numbered link other than the source whose address equals the header. Failing that, it is output 3 if the header equals the local address. A link's own address never routes back to itself.
- R4: A header that selects no destination under R3 delivers the packet on output 3 and sets the error bit.
- R5: A normal end marker (9'h100) and an error end marker (9'h101) both close a packet. Each is forwarded unchanged.
- R6: A packet made only of a header and its end marker produces the end marker alone on the selected output.
- R7: With routing enabled, an end marker that arrives where a header is expected is consumed. Nothing appears at any output and the error bit does not change.
- R8: Once an output is granted, it carries only that source's characters until the end marker has been transferred. Packets from different sources never interleave on one output.
- R9: Sources competing for a free output are served in round-robin order. After reset the search starts at input 0; after a release it starts at the input following the one just served. A waiting source holds ready low.
- R10: Ready low on an output stalls the owning source. No character is lost or duplicated.
- R11: With routing disabled at packet start, the whole packet, first character included, goes to output 3 and the error bit is not set.
- R12: The error bit stays set until a clear pulse. The interrupt equals the error bit ANDed with the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| route_en | input | 1 | 1 = header routing, 0 = transparent delivery to local |
| link_addr | input | 24 | Link addresses, link k in bits [8k+7:8k] |
| local_addr | input | 8 | Local node address |
| in_valid | input | 3 | Character valid per link input |
| in_data | input | 27 | Characters, input i in bits [9i+8:9i] |
| in_ready | output | 3 | Input accepts a character |
| out_valid | output | 4 | Character valid per output (3 = local) |
| out_data | output | 36 | Characters, output j in bits [9j+8:9j] |
| out_ready | input | 4 | Sink accepts a character |
| err_clr | input | 1 | Clear pulse for the error bit |
| err_mask | input | 1 | Interrupt enable |
| err_pending | output | 1 | Sticky unmatched-address bit |
| err_irq | output | 1 | Masked error interrupt |

## Verification
A wrong source state or lock register shows up at the ports within the packet it damages. A lost header deletion adds an extra first character. A wrong destination places the whole packet on another output. A lock released early lets a second source's characters cut into a stream, which breaks the per-source byte pattern at the very next transfer. A faulty round-robin pointer reverses the order of two contending packets at the local output. A broken sticky bit or mask shows up on the error outputs one cycle after the header that should have set it, or after the clear pulse.

// File: rtl/wh_rt_pkg.sv
package wh_rt_pkg;
  localparam int DW    = 8;
  localparam int CW    = DW + 1;
  localparam int NLINK = 3;
  localparam int NOUT  = NLINK + 1;
  localparam int IW    = $clog2(NLINK);
  localparam int PW    = $clog2(NOUT);

  typedef enum logic [1:0] {ST_HDR, ST_WAIT, ST_FWD} ing_st_t;

  function automatic logic is_end(input logic [CW-1:0] c);
    return c[CW-1];
  endfunction

  // Returns {miss, port}; lowest eligible link first, then local, else local+miss.
  function automatic logic [PW:0] route_lookup(input logic [DW-1:0] hdr, input int self,
                                               input logic [NLINK*DW-1:0] la,
                                               input logic [DW-1:0] loc);
    logic [PW:0] r;
    r = {1'b1, PW'(NLINK)};
    if (hdr == loc) r = {1'b0, PW'(NLINK)};
    for (int k = NLINK - 1; k >= 0; k--)
      if (k != self && la[k*DW +: DW] == hdr) r = {1'b0, PW'(k)};
    return r;
  endfunction

  // Returns {found, index}; smallest offset from ptr wins.
  function automatic logic [IW:0] rr_pick(input logic [NLINK-1:0] req, input logic [IW-1:0] ptr);
    logic [IW:0] r;
    int c;
    r = '0;
    for (int o = NLINK - 1; o >= 0; o--) begin
      c = (int'(ptr) + o) % NLINK;
      if (req[c]) r = {1'b1, IW'(c)};
    end
    return r;
  endfunction

  function automatic logic [IW-1:0] rr_next(input logic [IW-1:0] cur);
    return (int'(cur) == NLINK - 1) ? '0 : cur + 1'b1;
  endfunction
endpackage

// File: rtl/wh_rt_ingress.sv
module wh_rt_ingress import wh_rt_pkg::*; #(
  parameter int SELF = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 route_en,
  input  logic [NLINK*DW-1:0]  la,
  input  logic [DW-1:0]        loc,
  input  logic                 in_valid,
  input  logic [CW-1:0]        in_data,
  output logic                 in_ready,
  input  logic [NOUT-1:0]      out_ready,
  input  logic                 gnt,
  output logic                 req,
  output logic [PW-1:0]        dest,
  output logic                 hdr_miss
);
  ing_st_t     st;
  logic [PW:0] lk;
  logic        hdr_data;

  assign lk       = route_lookup(in_data[DW-1:0], SELF, la, loc);
  assign hdr_data = (st == ST_HDR) && route_en && in_valid && !is_end(in_data);
  assign hdr_miss = hdr_data && lk[PW];
  assign req      = (st == ST_WAIT);

  always_comb begin
    case (st)
      ST_HDR:  in_ready = route_en;
      ST_FWD:  in_ready = out_ready[dest];
      default: in_ready = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_HDR;
      dest <= PW'(NLINK);
    end else begin
      case (st)
        ST_HDR: begin
          if (in_valid && !route_en) begin
            dest <= PW'(NLINK);
            st   <= ST_WAIT;
          end else if (hdr_data) begin
            dest <= lk[PW-1:0];
            st   <= ST_WAIT;
          end
        end
        ST_WAIT: if (gnt) st <= ST_FWD;
        ST_FWD:  if (in_valid && in_ready && is_end(in_data)) st <= ST_HDR;
        default: st <= ST_HDR;
      endcase
    end
  end

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !gnt) |=> (st == ST_WAIT)); // R9
  AST_WAIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !in_ready); // R9
  AST_DEST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_HDR) |=> $stable(dest)); // R8
  AST_NO_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_HDR) |-> (dest != PW'(SELF))); // R3
endmodule

// File: rtl/wh_rt_arb.sv
module wh_rt_arb import wh_rt_pkg::*; #(
  parameter int OUT_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINK-1:0] req,
  input  logic             rel,
  output logic [NLINK-1:0] gnt,
  output logic             busy,
  output logic [IW-1:0]    owner
);
  logic [IW-1:0] ptr;
  logic [IW:0]   pick;

  assign pick = rr_pick(req, ptr);
  assign gnt  = (!busy && pick[IW]) ? (NLINK'(1) << pick[IW-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= '0;
      ptr   <= '0;
    end else if (!busy && pick[IW]) begin
      busy  <= 1'b1;
      owner <= pick[IW-1:0];
    end else if (busy && rel) begin
      busy <= 1'b0;
      ptr  <= rr_next(owner);
    end
  end

  AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rel) |=> (busy && $stable(owner))); // R8
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R9
  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0); // R9

  if (OUT_IDX < NLINK) begin : g_link
    AST_NO_LOOPBACK: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (owner != IW'(OUT_IDX))); // R3
  end
endmodule

// File: rtl/wh_rt_err.sv
module wh_rt_err (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic mask,
  output logic pending,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)   pending <= 1'b0;
    else if (set) pending <= 1'b1;
    else if (clr) pending <= 1'b0;
  end

  assign irq = pending & mask;

  AST_MISS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pending); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr) |=> pending); // R12
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !set) |=> !pending); // R12
endmodule

// File: rtl/wh_router.sv
module wh_router import wh_rt_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 route_en,
  input  logic [NLINK*DW-1:0]  link_addr,
  input  logic [DW-1:0]        local_addr,
  input  logic [NLINK-1:0]     in_valid,
  input  logic [NLINK*CW-1:0]  in_data,
  output logic [NLINK-1:0]     in_ready,
  output logic [NOUT-1:0]      out_valid,
  output logic [NOUT*CW-1:0]   out_data,
  input  logic [NOUT-1:0]      out_ready,
  input  logic                 err_clr,
  input  logic                 err_mask,
  output logic                 err_pending,
  output logic                 err_irq
);
  logic [NLINK-1:0] ing_req;
  logic [NLINK-1:0] ing_gnt;
  logic [NLINK-1:0] ing_miss;
  logic [PW-1:0]    ing_dest [NLINK];
  logic [NLINK-1:0] req_m    [NOUT];
  logic [NLINK-1:0] gnt_m    [NOUT];
  logic [IW-1:0]    own_m    [NOUT];
  logic [NOUT-1:0]  busy;
  logic [NOUT-1:0]  rel;

  for (genvar i = 0; i < NLINK; i++) begin : g_in
    wh_rt_ingress #(.SELF(i)) u_ing (
      .clk(clk), .rst_n(rst_n), .route_en(route_en),
      .la(link_addr), .loc(local_addr),
      .in_valid(in_valid[i]), .in_data(in_data[i*CW +: CW]), .in_ready(in_ready[i]),
      .out_ready(out_ready), .gnt(ing_gnt[i]),
      .req(ing_req[i]), .dest(ing_dest[i]), .hdr_miss(ing_miss[i])
    );
  end

  always_comb begin
    for (int j = 0; j < NOUT; j++)
      for (int i = 0; i < NLINK; i++)
        req_m[j][i] = ing_req[i] && (ing_dest[i] == PW'(j));
  end

  for (genvar j = 0; j < NOUT; j++) begin : g_out
    wh_rt_arb #(.OUT_IDX(j)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req_m[j]), .rel(rel[j]),
      .gnt(gnt_m[j]), .busy(busy[j]), .owner(own_m[j])
    );
  end

  always_comb begin
    ing_gnt = '0;
    for (int j = 0; j < NOUT; j++) begin
      ing_gnt |= gnt_m[j];
      out_valid[j]          = busy[j] && in_valid[own_m[j]];
      out_data[j*CW +: CW]  = in_data[own_m[j]*CW +: CW];
      rel[j]                = out_valid[j] && out_ready[j] && is_end(out_data[j*CW +: CW]);
    end
  end

  wh_rt_err u_err (
    .clk(clk), .rst_n(rst_n), .set(|ing_miss), .clr(err_clr), .mask(err_mask),
    .pending(err_pending), .irq(err_irq)
  );

  for (genvar i = 0; i < NLINK; i++) begin : g_chk
    logic [NOUT-1:0] gcol;
    for (genvar j = 0; j < NOUT; j++) begin : g_bit
      assign gcol[j] = gnt_m[j][i];
    end
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gcol)); // R8
  end
endmodule

// File: tb/wh_router_tb.sv
`timescale 1ns/1ps
module wh_router_tb;
  localparam time TCK = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        route_en = 1'b1;
  logic        in_v [3];
  logic [8:0]  in_d [3];
  logic [3:0]  out_rdy = 4'hF;
  logic        err_clr = 1'b0, err_mask = 1'b0;
  byte unsigned la [3];
  byte unsigned loc;

  logic [2:0]  in_valid, in_ready;
  logic [26:0] in_data;
  logic [3:0]  out_valid;
  logic [35:0] out_data;
  logic [23:0] link_addr;
  logic        err_pending, err_irq;

  assign in_valid  = {in_v[2], in_v[1], in_v[0]};
  assign in_data   = {in_d[2], in_d[1], in_d[0]};
  assign link_addr = {la[2], la[1], la[0]};

  wh_router u_dut (
    .clk(clk), .rst_n(rst_n), .route_en(route_en), .link_addr(link_addr),
    .local_addr(loc), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_rdy),
    .err_clr(err_clr), .err_mask(err_mask), .err_pending(err_pending), .err_irq(err_irq)
  );

  always #(TCK/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;
  bit rand_rdy = 0, hold1 = 0;
  logic [8:0] olog [4][256];
  int ocnt [4];
  bit e_act [3];
  int e_dst [3], e_len [3];
  bit e_eep [3];

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  function automatic byte unsigned pay(input int s, input int k);
    return byte'({s[1:0], k[5:0]});
  endfunction

  function automatic logic [8:0] endc(input bit eep);
    return {1'b1, 7'd0, eep};
  endfunction

  // -1 means no match: delivered locally with the error bit
  function automatic int exp_dest(input int src, input byte unsigned h);
    int d = -1;
    for (int k = 0; k < 3; k++)
      if (d < 0 && k != src && la[k] == h) d = k;
    if (d < 0 && h == loc) d = 3;
    return d;
  endfunction

  always @(posedge clk) begin
    logic [3:0] r;
    #1;
    r = rand_rdy ? 4'($urandom) : 4'hF;
    if (hold1) r[1] = 1'b0;
    out_rdy = r;
  end

  always @(negedge clk) begin
    if (rst_n)
      for (int j = 0; j < 4; j++)
        if (out_valid[j] && out_rdy[j] && ocnt[j] < 256) begin
          olog[j][ocnt[j]] = out_data[j*9 +: 9];
          ocnt[j]++;
        end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic clear_logs();
    for (int j = 0; j < 4; j++) ocnt[j] = 0;
    for (int s = 0; s < 3; s++) e_act[s] = 0;
  endtask

  task automatic send_char(input int i, input logic [8:0] c);
    in_v[i] = 1'b1;
    in_d[i] = c;
    @(negedge clk);
    while (!in_ready[i]) @(negedge clk);
    @(posedge clk); #1;
    in_v[i] = 1'b0;
  endtask

  task automatic send_pkt(input int i, input bit hdr_on, input byte unsigned h,
                          input int len, input bit eep);
    if (hdr_on) send_char(i, {1'b0, h});
    for (int k = 0; k < len; k++) send_char(i, {1'b0, pay(i, k)});
    send_char(i, endc(eep));
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1; tick(1); err_clr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(1);
  endtask

  task automatic verify(input string rq);
    for (int j = 0; j < 4; j++) begin
      int pos = 0, npk = 0, nexp = 0;
      for (int s = 0; s < 3; s++) if (e_act[s] && e_dst[s] == j) nexp++;
      while (pos < ocnt[j]) begin
        int s;
        bit ok = 1;
        s = int'(olog[j][pos][7:6]);
        if (olog[j][pos][8] || s > 2 || !e_act[s] || e_dst[s] != j) begin
          chk(0, rq, $sformatf("stray packet start on out %0d", j), int'(olog[j][pos]), j);
          break;
        end
        if (pos + e_len[s] >= ocnt[j]) ok = 0;
        else begin
          for (int k = 0; k < e_len[s]; k++)
            if (olog[j][pos+k] != {1'b0, pay(s, k)}) ok = 0;
          if (olog[j][pos+e_len[s]] != endc(e_eep[s])) ok = 0;
        end
        chk(ok, rq, $sformatf("content of packet from %0d on out %0d", s, j), ok, 1);
        pos += e_len[s] + 1;
        npk++;
      end
      chk(npk == nexp, rq, $sformatf("packet count on out %0d", j), npk, nexp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(TCK * 150000);
    nchk++; nfail++;
    $display("FAIL R8 watchdog: act=hung exp=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int s = 0; s < 3; s++) begin in_v[s] = 0; in_d[s] = '0; end
    la[0] = 8'h11; la[1] = 8'h22; la[2] = 8'h33; loc = 8'h44;
    clear_logs();
    tick(1);
    do_reset();

    // R1 reset state
    @(negedge clk);
    chk(out_valid == 4'h0, "R1", "out_valid after reset", out_valid, 0);
    chk(err_pending == 0 && err_irq == 0, "R1", "error outputs after reset", {err_pending, err_irq}, 0);
    chk(in_ready == 3'b111, "R1", "in_ready after reset", in_ready, 3'b111);
    tick(1);

    // R9 round robin, R8 no interleave: input 0 first, then 0 and 1 contend
    clear_logs();
    send_pkt(0, 1, loc, 2, 0);
    tick(2);
    fork
      send_pkt(0, 1, loc, 2, 0);
      send_pkt(1, 1, loc, 2, 1);
    join
    tick(3);
    chk(ocnt[3] == 9, "R9", "chars at local after contention", ocnt[3], 9);
    chk(olog[3][3][7:6] == 2'd1, "R9", "second packet source (round robin)", olog[3][3][7:6], 1);
    chk(olog[3][6][7:6] == 2'd0, "R9", "third packet source", olog[3][6][7:6], 0);
    chk(olog[3][5] == endc(1) && olog[3][4] == {1'b0, pay(1, 1)}, "R8", "contiguous packet from 1",
        olog[3][4], {1'b0, pay(1, 1)});
    chk(err_pending == 0, "R2", "no error on matched headers", err_pending, 0);

    // R6 header only
    clear_logs();
    send_pkt(0, 1, la[2], 0, 0);
    tick(3);
    chk(ocnt[2] == 1 && olog[2][0] == endc(0), "R6", "header-only packet gives lone end", olog[2][0], endc(0));

    // R7 end marker in header position
    clear_logs();
    send_char(1, endc(1));
    tick(4);
    chk(ocnt[0] + ocnt[1] + ocnt[2] + ocnt[3] == 0, "R7", "chars out after stray end",
        ocnt[0] + ocnt[1] + ocnt[2] + ocnt[3], 0);
    chk(err_pending == 0, "R7", "error bit after stray end", err_pending, 0);

    // R3 duplicate link addresses and own address exclusion
    la[1] = 8'h55; la[2] = 8'h55;
    clear_logs();
    e_act[0] = 1; e_dst[0] = 1; e_len[0] = 3; e_eep[0] = 0;
    e_act[1] = 1; e_dst[1] = 2; e_len[1] = 2; e_eep[1] = 1;
    send_pkt(0, 1, 8'h55, 3, 0);
    send_pkt(1, 1, 8'h55, 2, 1);
    tick(3);
    verify("R3");
    chk(err_pending == 0, "R3", "no error for duplicate match", err_pending, 0);
    la[1] = 8'h22; la[2] = 8'h33;

    // R10 backpressure on link 1
    clear_logs();
    hold1 = 1;
    e_act[0] = 1; e_dst[0] = 1; e_len[0] = 4; e_eep[0] = 0;
    fork
      send_pkt(0, 1, la[1], 4, 0);
      begin
        tick(10);
        chk(ocnt[1] == 0, "R10", "chars through a stalled output", ocnt[1], 0);
        chk(in_ready[0] == 0, "R10", "source ready while stalled", in_ready[0], 0);
        hold1 = 0;
      end
    join
    tick(3);
    verify("R10");

    // R11 transparent mode
    route_en = 1'b0;
    clear_logs();
    e_act[2] = 1; e_dst[2] = 3; e_len[2] = 3; e_eep[2] = 1;
    send_pkt(2, 0, 8'h00, 3, 1);
    tick(3);
    verify("R11");
    chk(err_pending == 0, "R11", "no error in transparent mode", err_pending, 0);
    route_en = 1'b1;

    // R4 / R12 unmatched header, sticky bit, mask, clear
    clear_logs();
    e_act[2] = 1; e_dst[2] = 3; e_len[2] = 1; e_eep[2] = 0;
    send_pkt(2, 1, la[2], 1, 0);
    tick(5);
    verify("R4");
    chk(err_pending == 1, "R4", "error bit after own-address header", err_pending, 1);
    chk(err_irq == 0, "R12", "irq with mask off", err_irq, 0);
    err_mask = 1'b1; tick(1);
    chk(err_irq == 1, "R12", "irq with mask on", err_irq, 1);
    pulse_clr(); tick(1);
    chk(err_pending == 0 && err_irq == 0, "R12", "error after clear", {err_pending, err_irq}, 0);
    err_mask = 1'b0;

    // Random rounds: R2 R3 R4 R5 R8 R10
    rand_rdy = 1;
    for (int rnd = 0; rnd < 60; rnd++) begin
      bit any_miss = 0;
      byte unsigned hh [3];
      clear_logs();
      for (int s = 0; s < 3; s++) begin
        int kind = $urandom % 5, d;
        if (kind < 3) hh[s] = la[kind];
        else if (kind == 3) hh[s] = loc;
        else hh[s] = byte'(8'hA0 | ($urandom % 16));
        d = exp_dest(s, hh[s]);
        if (d < 0) begin any_miss = 1; d = 3; end
        e_act[s] = 1; e_dst[s] = d; e_len[s] = 1 + $urandom % 6; e_eep[s] = 1'($urandom % 2);
      end
      for (int s = 0; s < 3; s++) begin
        fork
          automatic int ss = s;
          begin
            tick($urandom % 3);
            send_pkt(ss, 1, hh[ss], e_len[ss], e_eep[ss]);
          end
        join_none
      end
      wait fork;
      tick(3);
      verify("R2/R5/R8");
      chk(err_pending == any_miss, "R4", "error bit after random round", err_pending, any_miss);
      pulse_clr();
    end
    rand_rdy = 0;
    tick(2);
    finish_up();
  end
endmodule